// File: doc/BRIEF.md
# Selectable-Period PWM Timer

This block is a 16-bit up-counter that drives one pulse-width-modulated output. The period is chosen from four fixed wrap limits with a 2-bit select. The duty cycle comes from a programmable compare value. The counter advances only on cycles where a count-source clock enable is high. That enable stands in for whichever internal or external count source the surrounding chip supplies.

An enable input starts and stops the timer. While the timer is disabled, the counter is held at zero and the output is held low. While it runs, the output is high from each wrap to zero until the counter reaches the compare value. Each wrap also produces a one-clock overflow pulse. A new period select takes effect only at a wrap, so a period already under way is never cut short or stretched.

Top module: `pwm_seltop_timer`

## Requirements
- R1: The select input picks the wrap limit: 2'b00 gives 0x00FF, 2'b01 gives 0x01FF, 2'b10 gives 0x03FF and 2'b11 gives 0xFFFF.
- R2: The counter rises by exactly one at each clock edge where both enable and count enable are high. It holds its value when count enable is low.
- R3: At a count-enabled edge where the counter equals the active wrap limit, the counter goes to 0. The overflow output is high for that one following clock only.
- R4: While enabled, a change on the select input is adopted only at a wrap. Until then, the old limit governs the period under way.
- R5: While enabled, the PWM output is high when the counter is below the compare value and low otherwise. It rises at the wrap to zero and falls when the counter reaches the compare value.
- R6: A compare value above the active limit keeps the output constantly high. A compare value of zero keeps it constantly low.
- R7: One clock after enable is low, the counter is 0 and both the PWM output and the overflow output are low, whatever the count enable does. While disabled, the select input is adopted directly.
- R8: While rst_n is low, the counter, the PWM output and the overflow output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Timer enable |
| top_sel_i | input | 2 | Wrap limit select |
| cmp_i | input | 16 | Compare value, sets the duty cycle |
| cnt_en_i | input | 1 | Count-source clock enable |
| ovf_o | output | 1 | One-clock pulse at each wrap |
| pwm_o | output | 1 | PWM output |
| count_o | output | 16 | Present counter value |

## Verification
The properties assume that the counter can only exceed the active limit through an illegal path. This holds because the limit changes only at a wrap, when the counter is zero, or while the timer is disabled, when the counter is also zero. The properties also sample the compare value in the same cycle that the output register uses it. The stimulus therefore changes the compare value and the select only on the falling clock edge, or while the timer is disabled, so each property sees the inputs the design registered. Before each table vector the bench disables the timer for a cycle, so every vector starts from a zero count and a freshly adopted limit.

// File: rtl/pwm_seltop_pkg.sv
// Package: shared types and constants for the selectable-period PWM timer.
// Assumes the counter is at least 16 bits wide, so that every fixed limit fits.
package pwm_seltop_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        LIM_8BIT  = 2'b00,
        LIM_9BIT  = 2'b01,
        LIM_10BIT = 2'b10,
        LIM_16BIT = 2'b11
    } lim_sel_e;

    // Map a select code to its fixed wrap limit, zero-extended to the counter width.
    function automatic logic [31:0] lim_value(input lim_sel_e sel);
        logic [31:0] v;
        unique case (sel)
            LIM_8BIT:  v = 32'h0000_00FF;
            LIM_9BIT:  v = 32'h0000_01FF;
            LIM_10BIT: v = 32'h0000_03FF;
            default:   v = 32'h0000_FFFF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pwm_lim_select.sv
// Module: holds the active wrap-limit select and presents the matching limit.
// Assumes that wrap_i is high only on an edge where the counter wraps. The
// select is adopted at a wrap or while the timer is disabled, never mid-period.
module pwm_lim_select
    import pwm_seltop_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 wrap_i,
    input  logic [SEL_W-1:0]     sel_i,
    output lim_sel_e             act_sel_o,
    output logic [CNT_W-1:0]     lim_o
);

    lim_sel_e   act_q;
    logic [31:0] lim_wide;

    // Adopt the requested select only at a wrap or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= LIM_8BIT;
        end else if (!en_i || wrap_i) begin
            act_q <= lim_sel_e'(sel_i);
        end
    end

    // Translate the active select into a limit of counter width.
    always_comb begin
        lim_wide = lim_value(act_q);
        lim_o    = lim_wide[CNT_W-1:0];
    end

    assign act_sel_o = act_q;

endmodule

// File: rtl/pwm_counter.sv
// Module: the period counter. It counts on enabled ticks, wraps after the
// limit and flags the wrap. Assumes lim_i changes only while the counter is 0.
module pwm_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o,
    output logic             ovf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             wrap;
    logic             ovf_q;

    // Next-count logic: clear when disabled, wrap at the limit, otherwise step.
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (!en_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q >= lim_i) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Count and overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= wrap;
        end
    end

    assign cnt_o      = cnt_q;
    assign cnt_next_o = cnt_d;
    assign wrap_o     = wrap;
    assign ovf_o      = ovf_q;

endmodule

// File: rtl/pwm_out_stage.sv
// Module: registered PWM output. The output is high while the next count is
// below the compare value, so it aligns with the count register. Assumes that
// cnt_next_i is the value the counter loads on this edge.
module pwm_out_stage #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             pwm_o
);

    logic pwm_q;

    // Level register: high from a wrap until the compare point, low when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= en_i && (cnt_next_i < cmp_i);
        end
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_seltop_timer.sv
// Module: top of the selectable-period PWM timer. It wires the limit select,
// the counter and the output stage together. Assumes a single clock, with the
// count source presented as a clock enable that is synchronous to clk.
module pwm_seltop_timer
    import pwm_seltop_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       top_sel_i,
    input  logic [15:0]      cmp_i,
    input  logic             cnt_en_i,
    output logic             ovf_o,
    output logic             pwm_o,
    output logic [15:0]      count_o
);

    localparam int unsigned PORT_W = 16;

    lim_sel_e         act_sel;
    logic [CNT_W-1:0] lim_val;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] cmp_ext;
    logic             wrap;

    // Widen or narrow the compare value to the counter width.
    generate
        if (CNT_W > PORT_W) begin : g_cmp_wide
            assign cmp_ext = {{(CNT_W-PORT_W){1'b0}}, cmp_i};
            assign count_o = cnt[PORT_W-1:0];
        end else begin : g_cmp_same
            assign cmp_ext = cmp_i[CNT_W-1:0];
            assign count_o = cnt;
        end
    endgenerate

    pwm_lim_select #(.CNT_W(CNT_W)) lim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .wrap_i    (wrap),
        .sel_i     (top_sel_i),
        .act_sel_o (act_sel),
        .lim_o     (lim_val)
    );

    pwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .tick_i     (cnt_en_i),
        .lim_i      (lim_val),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap),
        .ovf_o      (ovf_o)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .cnt_next_i (cnt_next),
        .cmp_i      (cmp_ext),
        .pwm_o      (pwm_o)
    );

endmodule

// File: rtl/pwm_seltop_timer_chk.sv
// Checker: temporal properties of the PWM timer, attached by bind.
module pwm_seltop_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic [1:0]       top_sel_i,
    input logic [15:0]      cmp_i,
    input logic             cnt_en_i,
    input logic             ovf_o,
    input logic             pwm_o,
    input logic [15:0]      count_o,
    input logic [1:0]       act_sel,
    input logic [CNT_W-1:0] lim_val
);

    // R2: with the count enable low, the count holds.
    p_hold_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cnt_en_i) |=> $stable(count_o));

    // R3: the overflow pulse coincides with a zero count and lasts one clock.
    p_ovf_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == 16'd0));
    p_ovf_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(count_o) <= lim_val));

    // R4: the active select changes only at a wrap or while disabled.
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !(cnt_en_i && CNT_W'(count_o) == lim_val)) |=> $stable(act_sel));

    // R6: a zero compare value keeps the output low.
    p_zero_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i == 16'd0) |=> !pwm_o);

    // R7: disabling clears the count and both outputs.
    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (count_o == 16'd0 && !pwm_o && !ovf_o));

    // R8: reset state, sampled while reset is held.
    always @(negedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            a_reset_r8: assert (count_o == 16'd0 && !pwm_o && !ovf_o);
        end
    end

endmodule

bind pwm_seltop_timer pwm_seltop_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .top_sel_i (top_sel_i),
    .cmp_i     (cmp_i),
    .cnt_en_i  (cnt_en_i),
    .ovf_o     (ovf_o),
    .pwm_o     (pwm_o),
    .count_o   (count_o),
    .act_sel   (act_sel),
    .lim_val   (lim_val)
);

// File: tb/pwm_seltop_timer_tb_top.sv
module pwm_seltop_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [1:0]  top_sel_i = 2'b00;
    logic [15:0] cmp_i = 16'h0;
    logic        cnt_en_i = 1'b0;
    logic        ovf_o;
    logic        pwm_o;
    logic [15:0] count_o;

    int checks = 0;
    int errors = 0;

    always #5ns clk = ~clk;

    pwm_seltop_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .top_sel_i (top_sel_i),
        .cmp_i     (cmp_i),
        .cnt_en_i  (cnt_en_i),
        .ovf_o     (ovf_o),
        .pwm_o     (pwm_o),
        .count_o   (count_o)
    );

    // Vector fields: sel[50:49] cmp[48:33] ticks[32:17] exp_count[16:1] exp_pwm[0]
    localparam int NV = 9;
    localparam logic [50:0] VEC [NV] = '{
        {2'b00, 16'h0080, 16'h0050, 16'h0050, 1'b1},
        {2'b00, 16'h0080, 16'h0090, 16'h0090, 1'b0},
        {2'b00, 16'h0080, 16'h0100, 16'h0000, 1'b1},
        {2'b01, 16'h0080, 16'h0100, 16'h0100, 1'b0},
        {2'b01, 16'h0080, 16'h0200, 16'h0000, 1'b1},
        {2'b10, 16'h03FF, 16'h0300, 16'h0300, 1'b1},
        {2'b10, 16'h0100, 16'h0400, 16'h0000, 1'b1},
        {2'b11, 16'h2000, 16'h1000, 16'h1000, 1'b1},
        {2'b00, 16'h01FF, 16'h01F0, 16'h00F0, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        cnt_en_i = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        cnt_en_i = 1'b0;
    endtask

    task automatic restart(input logic [1:0] sel, input logic [15:0] cmp);
        en_i = 1'b0;
        top_sel_i = sel;
        cmp_i = cmp;
        @(negedge clk);
        en_i = 1'b1;
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 count", count_o, 16'h0);
        check("R8 pwm", {15'h0, pwm_o}, 16'h0);
        check("R8 ovf", {15'h0, ovf_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R5 R6
        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][50:49], VEC[v][48:33]);
            ticks(int'(VEC[v][32:17]));
            check("R1 R2 count", count_o, VEC[v][16:1]);
            check("R5 R6 pwm", {15'h0, pwm_o}, {15'h0, VEC[v][0]});
        end

        // R2: count holds without count enable
        restart(2'b00, 16'h0080);
        ticks(7);
        repeat (5) @(negedge clk);
        check("R2 hold", count_o, 16'h7);

        // R3: wrap at 0xFF with a single overflow pulse
        restart(2'b00, 16'h0080);
        ticks(255);
        check("R3 at limit", count_o, 16'hFF);
        check("R3 no ovf yet", {15'h0, ovf_o}, 16'h0);
        ticks(1);
        check("R3 wrapped", count_o, 16'h0);
        check("R3 ovf pulse", {15'h0, ovf_o}, 16'h1);
        check("R5 high after wrap", {15'h0, pwm_o}, 16'h1);
        @(negedge clk);
        check("R3 ovf cleared", {15'h0, ovf_o}, 16'h0);

        // R4: select change mid-period waits for the wrap
        restart(2'b00, 16'h0080);
        ticks(16'h10);
        top_sel_i = 2'b01;
        ticks(16'hEF);
        check("R4 old limit reached", count_o, 16'hFF);
        ticks(1);
        check("R4 wrapped at old limit", count_o, 16'h0);
        ticks(16'h100);
        check("R4 new limit active", count_o, 16'h100);
        check("R4 no ovf", {15'h0, ovf_o}, 16'h0);

        // R5: falls exactly at the compare value
        restart(2'b00, 16'h0020);
        ticks(16'h1F);
        check("R5 below compare", {15'h0, pwm_o}, 16'h1);
        ticks(1);
        check("R5 at compare", {15'h0, pwm_o}, 16'h0);

        // R6: zero compare stays low
        restart(2'b00, 16'h0000);
        ticks(16'h180);
        check("R6 zero compare", {15'h0, pwm_o}, 16'h0);

        // R7: disable clears, count enable ignored while disabled
        restart(2'b00, 16'h0080);
        ticks(16'h30);
        en_i = 1'b0;
        cnt_en_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 count cleared", count_o, 16'h0);
        check("R7 pwm low", {15'h0, pwm_o}, 16'h0);
        check("R7 ovf low", {15'h0, ovf_o}, 16'h0);
        cnt_en_i = 1'b0;
        // R7: select adopted directly while disabled
        top_sel_i = 2'b01;
        @(negedge clk);
        en_i = 1'b1;
        ticks(16'h180);
        check("R7 select adopted", count_o, 16'h180);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule